// File: doc/BRIEF.md
# Per-Core Compare Timer

This block is a per-core system timer. It keeps a free-running 64-bit count that advances by one on every clock. Software reaches it through a small synchronous register bus. Through that bus it reads a fixed frequency constant, the physical count, and a virtual count (the physical count minus a programmable offset). It also programs a relative timer value and a control word. A timer-value write arms a compare deadline at the current count plus the written value. The block then drives one level-sensitive interrupt toward the core's interrupt controller.

The compare side is a two-state machine. In ST_WAIT the status bit reads 0 and the deadline is pending. When the timer is enabled and the count has reached the deadline, the transition T_HIT moves it to ST_EXPIRED, where the status bit reads 1. From either state, a timer-value write takes T_REARM back to ST_WAIT with a new deadline. No other event leaves ST_EXPIRED. Software cannot clear the status through the control word; it can only change the enable and mask bits. The interrupt is the status gated by enable and by the inverted mask.

Top module: `cmp_timer`

## Requirements
- R1: The physical count is 0 in the first cycle after reset and grows by exactly one per clock. A read of address 1 returns it.
- R2: Address 3 is a read/write 64-bit offset. A read of address 2 returns the physical count minus the offset, modulo 2^64.
- R3: Address 0 reads the constant 1,000,000,000 and address 4 reads 0. Writes to addresses 0, 1, 2, 4 and 7 change no state. Address 7 reads 0.
- R4: Address 6 is the control word: bit 0 enable, bit 1 mask, bit 2 status, all other bits 0. A write to it loads only bits 0 and 1 from the write data. Status keeps its value, even if bit 2 of the data is 1 or 0.
- R5: A write of V to address 5 in a cycle where the count is C sets the deadline to C + V and clears the status. V is the low 32 bits, sign-extended. The interrupt is low in the cycle after that write.
- R6: While enabled in ST_WAIT, the status sets on the first clock edge at which the count is at or beyond the deadline. The interrupt is high exactly V cycles after a write of V ≥ 1, and 1 cycle after a write of 0.
- R7: The interrupt equals enable AND status AND NOT mask. It follows a control write in the very next cycle.
- R8: While enable is 0 the status does not change except through a timer-value write, and the interrupt is low. Enabling with a deadline already passed sets the status one edge after the enabling write.
- R9: A read of address 5 returns the low 32 bits of (deadline − count) at the read cycle, sign-extended to 64 bits.
- R10: Reset clears count, offset, deadline, enable, mask and status, and holds the interrupt low.
- R11: A read request (select high, write-enable low) returns its data on the read-data port in the next cycle. The data holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, one cycle after the request |
| irq_o | output | 1 | Level interrupt of the physical timer |

## Verification
The compare path is tried with several armed values: 1, 3, 7, 20, and 0. For each, the cycles to the interrupt are counted, which separates a correct deadline from off-by-one and equality-only compares. Separate mask, disable and status-write sequences tell the status bit apart from the interrupt gating, and they show that software cannot clear the status. Back-to-back count and offset reads distinguish a one-cycle read path from a stale or doubled one. Reading the timer value after the deadline has passed exposes the sign extension.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_FREQ = 3'd0,
        A_PCNT = 3'd1,
        A_VCNT = 3'd2,
        A_VOFF = 3'd3,
        A_KCTL = 3'd4,
        A_TVAL = 3'd5,
        A_CTL  = 3'd6
    } reg_addr_e;

    localparam int CTL_EN   = 0;
    localparam int CTL_MASK = 1;
    localparam int CTL_STAT = 2;

    typedef enum logic {
        ST_WAIT,
        ST_EXPIRED
    } cmp_state_e;
endpackage

// File: rtl/cmp_timer_counter.sv
module cmp_timer_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] count_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    assign count_o = cnt_q;

    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/cmp_timer_fsm.sv
module cmp_timer_fsm
    import cmp_timer_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_i,
    input  logic             rearm_i,
    input  logic [CNT_W-1:0] rel_i,
    input  logic             ctl_we_i,
    input  logic             en_in,
    input  logic             mask_in,
    output logic             en_o,
    output logic             mask_o,
    output logic             status_o,
    output logic             irq_o,
    output logic [CNT_W-1:0] deadline_o
);
    cmp_state_e       state_q, state_d;
    logic [CNT_W-1:0] deadline_q;
    logic             en_q, mask_q;
    logic             hit;

    assign hit = en_q && (count_i >= deadline_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT:     if (rearm_i) state_d = ST_WAIT;
                         else if (hit) state_d = ST_EXPIRED;
            ST_EXPIRED:  if (rearm_i) state_d = ST_WAIT;
            default:     state_d = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_WAIT;
            deadline_q <= '0;
            en_q       <= 1'b0;
            mask_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            if (rearm_i) deadline_q <= count_i + rel_i;
            if (ctl_we_i) begin
                en_q   <= en_in;
                mask_q <= mask_in;
            end
        end
    end

    always_comb begin
        status_o   = (state_q == ST_EXPIRED);
        irq_o      = en_q && status_o && !mask_q;
        en_o       = en_q;
        mask_o     = mask_q;
        deadline_o = deadline_q;
    end

    assert_status_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o && !rearm_i) |=> status_o);
    assert_disabled_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !rearm_i) |=> $stable(status_o));
    assert_rearm_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rearm_i |=> (!status_o && !irq_o));
    assert_hit_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !rearm_i && (count_i >= deadline_q)) |=> status_o);
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import cmp_timer_pkg::*;
#(
    parameter int          CNT_W   = 64,
    parameter int          TVAL_W  = 32,
    parameter logic [63:0] FREQ_HZ = 64'd1000000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq_o
);
    localparam int EXT_W = CNT_W - TVAL_W;

    logic [CNT_W-1:0] count, deadline, voff_q, rd_val, rdata_q, tval_diff, rel;
    logic             en, mask, status;
    logic             wr, rd, tval_we, ctl_we, voff_we;

    assign wr      = bus_sel && bus_we;
    assign rd      = bus_sel && !bus_we;
    assign tval_we = wr && (bus_addr == A_TVAL);
    assign ctl_we  = wr && (bus_addr == A_CTL);
    assign voff_we = wr && (bus_addr == A_VOFF);
    assign rel     = {{EXT_W{bus_wdata[TVAL_W-1]}}, bus_wdata[TVAL_W-1:0]};

    cmp_timer_counter #(.CNT_W(CNT_W)) i_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_o (count)
    );

    cmp_timer_fsm #(.CNT_W(CNT_W)) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .count_i    (count),
        .rearm_i    (tval_we),
        .rel_i      (rel),
        .ctl_we_i   (ctl_we),
        .en_in      (bus_wdata[CTL_EN]),
        .mask_in    (bus_wdata[CTL_MASK]),
        .en_o       (en),
        .mask_o     (mask),
        .status_o   (status),
        .irq_o      (irq_o),
        .deadline_o (deadline)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)       voff_q <= '0;
        else if (voff_we) voff_q <= bus_wdata;
    end

    assign tval_diff = deadline - count;

    always_comb begin
        rd_val = '0;
        unique case (bus_addr)
            A_FREQ: rd_val = FREQ_HZ;
            A_PCNT: rd_val = count;
            A_VCNT: rd_val = count - voff_q;
            A_VOFF: rd_val = voff_q;
            A_KCTL: rd_val = '0;
            A_TVAL: rd_val = {{EXT_W{tval_diff[TVAL_W-1]}}, tval_diff[TVAL_W-1:0]};
            A_CTL: begin
                rd_val[CTL_EN]   = en;
                rd_val[CTL_MASK] = mask;
                rd_val[CTL_STAT] = status;
            end
            default: rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)  rdata_q <= '0;
        else if (rd) rdata_q <= rd_val;
    end

    assign bus_rdata = rdata_q;

    assert_ctl_write_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && !bus_wdata[CTL_EN]) |=> !irq_o);
    assert_voff_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        voff_we |=> (voff_q == $past(bus_wdata)));
    assert_read_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(bus_rdata));
endmodule

// File: tb/test_cmp_timer.sv
module test_cmp_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic        irq_o;

    int n_tests = 0;
    int n_fail  = 0;

    // stimulus {tval written, expected cycles until irq}
    localparam logic [63:0] VEC [5] = '{
        {32'd1,  32'd1},
        {32'd3,  32'd3},
        {32'd7,  32'd7},
        {32'd20, 32'd20},
        {32'd0,  32'd1}
    };

    always #(CLK_PERIOD/2) clk = ~clk;

    cmp_timer i_cmp_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic wr(input logic [2:0] a, input logic [63:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [63:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] a, b;
        int n;
        idle(3);
        chk("R10 irq in reset", {63'd0, irq_o}, 64'd0);
        rst_n = 1'b1;
        rd(3'd1, a);
        chk("R10 count after reset", a, 64'd0);
        rd(3'd6, a);
        chk("R10 ctl after reset", a, 64'd0);
        rd(3'd1, a);
        rd(3'd1, b);
        chk("R1 count step", b - a, 64'd1);
        chk("R11 read latency", a, 64'd2);
        idle(2);
        chk("R11 read data held", bus_rdata, 64'd3);

        rd(3'd0, a);
        chk("R3 freq", a, 64'd1000000000);
        rd(3'd4, a);
        chk("R3 kernel ctl", a, 64'd0);
        wr(3'd0, 64'd5);
        wr(3'd7, 64'd9);
        rd(3'd0, a);
        chk("R3 freq write ignored", a, 64'd1000000000);
        rd(3'd7, a);
        chk("R3 unmapped reads 0", a, 64'd0);

        wr(3'd3, 64'd100);
        rd(3'd3, a);
        chk("R2 offset readback", a, 64'd100);
        rd(3'd1, a);
        rd(3'd2, b);
        chk("R2 virtual count", b, a + 64'd1 - 64'd100);
        wr(3'd3, 64'hFFFF_FFFF_FFFF_0000);
        rd(3'd1, a);
        rd(3'd2, b);
        chk("R2 virtual wrap", b, a + 64'd1 - 64'hFFFF_FFFF_FFFF_0000);

        // timer-value read, disabled timer
        wr(3'd5, 64'd50);
        rd(3'd5, a);
        chk("R9 tval read", a, 64'd49);

        // vector loop: enabled, unmasked
        wr(3'd6, 64'd1);
        for (int v = 0; v < 5; v++) begin
            wr(3'd5, {32'd0, VEC[v][63:32]});
            chk("R5 irq low after rearm", {63'd0, irq_o}, 64'd0);
            n = 0;
            while (!irq_o && n < 100) begin
                @(negedge clk);
                n++;
            end
            chk("R6 cycles to irq", n, {32'd0, VEC[v][31:0]});
        end

        // R9 negative remaining time
        wr(3'd5, 64'd2);
        idle(4);
        rd(3'd5, a);
        chk("R9 negative tval", a, 64'hFFFF_FFFF_FFFF_FFFD);

        // mask gating
        wr(3'd6, 64'd3);
        wr(3'd5, 64'd2);
        idle(4);
        chk("R7 masked irq low", {63'd0, irq_o}, 64'd0);
        rd(3'd6, a);
        chk("R4 ctl with status", a, 64'd7);
        wr(3'd6, 64'd1);
        chk("R7 unmask raises irq", {63'd0, irq_o}, 64'd1);
        wr(3'd6, 64'h0000_0000_0000_00F8);
        rd(3'd6, a);
        chk("R4 status not writable", a, 64'd4);
        chk("R8 disabled irq low", {63'd0, irq_o}, 64'd0);
        wr(3'd6, 64'd1);
        chk("R7 re-enable raises irq", {63'd0, irq_o}, 64'd1);
        wr(3'd5, 64'd1000);
        chk("R5 rearm lowers irq", {63'd0, irq_o}, 64'd0);
        rd(3'd6, a);
        chk("R5 rearm clears status", a, 64'd1);

        // disabled past deadline
        wr(3'd6, 64'd0);
        wr(3'd5, 64'd3);
        idle(10);
        rd(3'd6, a);
        chk("R8 status held while disabled", a, 64'd0);
        wr(3'd6, 64'd1);
        chk("R8 no irq on enabling edge", {63'd0, irq_o}, 64'd0);
        idle(1);
        chk("R8 irq one edge after enable", {63'd0, irq_o}, 64'd1);

        // reset mid-run
        wr(3'd3, 64'd77);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        chk("R10 irq after reset", {63'd0, irq_o}, 64'd0);
        rd(3'd3, a);
        chk("R10 offset cleared", a, 64'd0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule